// File: doc/BRIEF.md
# Byte-Lane Word Access Sequencer

This block connects a processor core to a 16-bit memory bus where every address names one byte. The core hands over one request at a time: a byte or a 16-bit word, read or write, at a 20-bit byte address. The sequencer turns each request into one or two bus cycles. It places write data on the correct byte lane and drives the lane selects. For reads it builds the 16-bit result from the lanes the memory returns.

A word whose first byte is at an even address moves in a single bus cycle on both lanes. A word at an odd address is split into two cycles. The first cycle uses the high lane at the given address. The second uses the low lane at the next address. A word keeps its low-order byte at the lower address.

Back-pressure on the core side works as follows. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. From that edge on, `req_ready` stays low until the edge that samples the acknowledge of the request's last bus cycle. While it is low, the request inputs are ignored. The memory may stretch any bus cycle with wait states by holding `bus_ack` low.

Top module: `word_access_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_req` is 0 and `rd_valid` is 0.
- R2: While `req_ready` is 1, a request is accepted on the edge where `req_valid` is 1. `req_ready` then stays 0 until the edge that samples `bus_ack` high in the request's final bus cycle; it is 1 again in the cycle after that edge. Request inputs that change while `req_ready` is 0 have no effect on the bus.
- R3: A word access (`req_word`=1) at an even address gives exactly one bus cycle. That cycle has `bus_addr` equal to the request address and `bus_hi_en`=1. Both lanes carry data.
- R4: A byte access (`req_word`=0) gives exactly one bus cycle at the request address. At an even address the byte uses the low lane, bits 7:0, and `bus_hi_en`=0. At an odd address it uses the high lane, bits 15:8, and `bus_hi_en`=1. On a byte write the other lane is driven with zero.
- R5: A word access at an odd address A gives two bus cycles. The first is at A with `bus_hi_en`=1. The second is at A+1 with `bus_hi_en`=0.
- R6: On a split word write, the first cycle drives write bits 7:0 on bus bits 15:8, with bits 7:0 zero. The second cycle drives write bits 15:8 on bus bits 7:0, with bits 15:8 zero.
- R7: A read delivers its result on `rd_data` with `rd_valid` high for exactly one cycle, in the cycle after the final acknowledge. A word read returns {byte at A+1, byte at A}. A byte read returns the byte zero-extended to 16 bits. Writes do not raise `rd_valid`.
- R8: While `bus_req` is 1 and `bus_ack` is 0, the next cycle keeps `bus_req`, `bus_addr`, `bus_we`, `bus_hi_en` and `bus_wdata` unchanged.
- R9: The address A+1 of a split access wraps modulo 2^20, so a word at 0xFFFFF continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | 20 | Byte address of the first byte |
| req_wdata | input | 16 | Write value; a byte write uses bits 7:0 |
| rd_valid | output | 1 | One-cycle pulse: read result present |
| rd_data | output | 16 | Read result, little-endian, bytes zero-extended |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Byte address of the bus cycle; bit 0 low selects the low lane |
| bus_hi_en | output | 1 | High lane (bits 15:8) selected |
| bus_wdata | output | 16 | Write data on both lanes |
| bus_rdata | input | 16 | Read data from memory, both lanes |
| bus_ack | input | 1 | Memory completes the current bus cycle |

## Verification
The hardest cases to reach from the ports are a split word whose second cycle wraps past the top of the address space, and a split word whose cycles are each stretched by wait states while the core keeps offering a different request. The sweep covers every low-address phase, both address extremes, every size and direction, and zero to two wait states per cycle. During every busy cycle it holds `req_valid` high with scrambled fields. The memory model returns data computed from the address, so each lane the sequencer picks can be told apart in the result.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_t;
endpackage

// File: rtl/wsq_lane_plan.sv
module wsq_lane_plan #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                  word_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*LANE_W-1:0]   wdata_i,
  input  logic                  second_i,
  output logic                  split_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  hi_en_o,
  output logic [2*LANE_W-1:0]   wdata_o
);
  localparam logic [LANE_W-1:0] ZERO_LANE = '0;

  logic [LANE_W-1:0] lo_src, hi_src;
  assign lo_src  = wdata_i[LANE_W-1:0];
  assign hi_src  = wdata_i[2*LANE_W-1:LANE_W];
  assign split_o = word_i & addr_i[0];

  // The second cycle always falls on an even address and the low lane.
  assign addr_o  = second_i ? addr_i + ADDR_W'(1) : addr_i;
  assign hi_en_o = second_i ? 1'b0 : (word_i | addr_i[0]);

  always_comb begin
    if (!word_i)
      wdata_o = addr_i[0] ? {lo_src, ZERO_LANE} : {ZERO_LANE, lo_src};
    else if (!split_o)
      wdata_o = wdata_i;
    else if (second_i)
      wdata_o = {ZERO_LANE, hi_src};
    else
      wdata_o = {lo_src, ZERO_LANE};
  end
endmodule

// File: rtl/wsq_read_merge.sv
module wsq_read_merge #(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  keep_first_i,
  input  logic                  finish_i,
  input  logic                  word_i,
  input  logic                  split_i,
  input  logic                  odd_i,
  input  logic [2*LANE_W-1:0]   bus_rdata_i,
  output logic                  rd_valid_o,
  output logic [2*LANE_W-1:0]   rd_data_o
);
  localparam logic [LANE_W-1:0] ZERO_LANE = '0;

  logic [LANE_W-1:0] held_q;
  logic [LANE_W-1:0] lane_lo, lane_hi;
  assign lane_lo = bus_rdata_i[LANE_W-1:0];
  assign lane_hi = bus_rdata_i[2*LANE_W-1:LANE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= finish_i;
      if (keep_first_i)
        held_q <= lane_hi;
      if (finish_i) begin
        if (split_i)
          rd_data_o <= {lane_lo, held_q};
        else if (word_i)
          rd_data_o <= bus_rdata_i;
        else if (odd_i)
          rd_data_o <= {ZERO_LANE, lane_hi};
        else
          rd_data_o <= {ZERO_LANE, lane_lo};
      end
    end
  end
endmodule

// File: rtl/word_access_seq.sv
module word_access_seq #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_word,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  output logic                  rd_valid,
  output logic [2*LANE_W-1:0]   rd_data,
  output logic                  bus_req,
  output logic                  bus_we,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_hi_en,
  output logic [2*LANE_W-1:0]   bus_wdata,
  input  logic [2*LANE_W-1:0]   bus_rdata,
  input  logic                  bus_ack
);
  import wsq_pkg::*;
  localparam int DATA_W = 2 * LANE_W;

  phase_t             phase_q;
  logic               wr_q, word_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               split_w;
  logic               take, last_ack;

  assign req_ready = (phase_q == PH_IDLE);
  assign take      = req_valid & req_ready;
  assign bus_req   = (phase_q != PH_IDLE);
  assign bus_we    = bus_req & wr_q;
  assign last_ack  = bus_ack & ((phase_q == PH_SECOND) |
                                ((phase_q == PH_FIRST) & ~split_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (take) begin
          phase_q <= PH_FIRST;
          wr_q    <= req_write;
          word_q  <= req_word;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
        end
        PH_FIRST:  if (bus_ack) phase_q <= split_w ? PH_SECOND : PH_IDLE;
        PH_SECOND: if (bus_ack) phase_q <= PH_IDLE;
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  wsq_lane_plan #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_plan (
    .word_i   (word_q),
    .addr_i   (addr_q),
    .wdata_i  (wdata_q),
    .second_i (phase_q == PH_SECOND),
    .split_o  (split_w),
    .addr_o   (bus_addr),
    .hi_en_o  (bus_hi_en),
    .wdata_o  (bus_wdata)
  );

  wsq_read_merge #(.LANE_W(LANE_W)) u_merge (
    .clk          (clk),
    .rst_n        (rst_n),
    .keep_first_i (bus_ack & ~wr_q & split_w & (phase_q == PH_FIRST)),
    .finish_i     (last_ack & ~wr_q),
    .word_i       (word_q),
    .split_i      (split_w),
    .odd_i        (addr_q[0]),
    .bus_rdata_i  (bus_rdata),
    .rd_valid_o   (rd_valid),
    .rd_data_o    (rd_data)
  );
endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 bus_req,
  input logic                 bus_ack,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_hi_en,
  input logic [2*LANE_W-1:0]  bus_wdata,
  input logic                 rd_valid,
  input wsq_pkg::phase_t      phase_q,
  input logic                 split_w
);
  import wsq_pkg::*;

  assert_hold_while_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_hi_en) && $stable(bus_wdata)));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !req_ready);

  assert_odd_uses_high_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr[0]) |-> bus_hi_en);

  assert_split_next_address_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FIRST && bus_ack && split_w) |=>
      (bus_req && !bus_hi_en && bus_addr == $past(bus_addr) + ADDR_W'(1)));

  assert_result_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(bus_ack) && !$past(bus_we)));
endmodule

bind word_access_seq wsq_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_hi_en (bus_hi_en),
  .bus_wdata (bus_wdata),
  .rd_valid  (rd_valid),
  .phase_q   (phase_q),
  .split_w   (split_w)
);

// File: tb/word_access_seq_test.sv
module word_access_seq_test;
  localparam int AW = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        req_ready, rd_valid, bus_req, bus_we, bus_hi_en;
  logic [15:0] rd_data, bus_wdata;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  word_access_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_hi_en(bus_hi_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  function automatic logic [7:0] memb(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h3C;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_cycle(input string req, input logic [AW-1:0] a, input logic hi,
                             input logic wr, input logic [15:0] wd);
    check({req, " bus_req"}, 32'(bus_req), 32'd1);
    check({req, " bus_addr"}, 32'(bus_addr), 32'(a));
    check({req, " bus_hi_en"}, 32'(bus_hi_en), 32'(hi));
    check({req, " bus_we"}, 32'(bus_we), 32'(wr));
    if (wr) check({req, " bus_wdata"}, 32'(bus_wdata), 32'(wd));
    check("R2 ready low while busy", 32'(req_ready), 32'd0);
  endtask

  // One request: at most two bus cycles, each stretched by 'waits' cycles.
  task automatic run_req(input logic wr, input logic wd_sel, input logic [AW-1:0] a,
                         input logic [15:0] w, input int waits);
    logic [AW-1:0] ca [2];
    logic          chi [2];
    logic [15:0]   cwd [2];
    int            n;
    logic          split;
    logic [15:0]   exp_rd;
    string         tag;
    split = wd_sel & a[0];
    n = split ? 2 : 1;
    ca[0] = a; ca[1] = a + AW'(1);
    if (!wd_sel) begin
      chi[0] = a[0]; cwd[0] = a[0] ? {w[7:0], 8'h00} : {8'h00, w[7:0]};
      exp_rd = {8'h00, memb(a)}; tag = "R4";
    end else if (!split) begin
      chi[0] = 1'b1; cwd[0] = w; exp_rd = {memb(a + AW'(1)), memb(a)}; tag = "R3";
    end else begin
      chi[0] = 1'b1; cwd[0] = {w[7:0], 8'h00};
      chi[1] = 1'b0; cwd[1] = {8'h00, w[15:8]};
      exp_rd = {memb(a + AW'(1)), memb(a)};
      tag = (a == {AW{1'b1}}) ? "R9" : "R5";
    end
    chi[1] = split ? 1'b0 : 1'b0;

    @(negedge clk);
    check("R2 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_word = wd_sel; req_addr = a; req_wdata = w;
    @(negedge clk);
    // Junk request held during the busy period must be ignored (R2).
    req_write = ~wr; req_word = ~wd_sel; req_addr = ~a; req_wdata = ~w;
    for (int c = 0; c < n; c++) begin
      string ct;
      ct = (split && wr) ? "R6" : tag;
      for (int k = 0; k < waits; k++) begin
        check_cycle(ct, ca[c], chi[c], wr, cwd[c]);
        bus_ack = 1'b0;
        @(negedge clk);
        check_cycle("R8 hold", ca[c], chi[c], wr, cwd[c]);
      end
      check_cycle(ct, ca[c], chi[c], wr, cwd[c]);
      bus_ack = 1'b1;
      bus_rdata = {memb(ca[c] | AW'(1)), memb(ca[c] & ~AW'(1))};
      @(negedge clk);
      bus_ack = 1'b0; bus_rdata = 16'hDEAD;
    end
    req_valid = 1'b0;
    check("R2 ready after final ack", 32'(req_ready), 32'd1);
    check("R3/R5 cycle count", 32'(bus_req), 32'd0);
    check("R7 rd_valid", 32'(rd_valid), 32'(!wr));
    if (!wr) check("R7 rd_data", 32'(rd_data), 32'(exp_rd));
    @(negedge clk);
    check("R7 pulse width", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    logic [AW-1:0] alist [8];
    alist = '{20'h00000, 20'h00001, 20'h00002, 20'h00003,
              20'h5A3C4, 20'h5A3C7, 20'hFFFFE, 20'hFFFFF};
    #1;
    check("R1 ready in reset", 32'(req_ready), 32'd1);
    check("R1 bus idle in reset", 32'(bus_req), 32'd0);
    check("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(bus_req), 32'd0);
    for (int i = 0; i < 8; i++)
      for (int op = 0; op < 4; op++)
        for (int wt = 0; wt < 3; wt++)
          run_req(op[1], op[0], alist[i], 16'hA5C3 ^ 16'(i * 16'h1111 + wt), wt);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule